// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects level-sensitive interrupt sources in groups of 32, called banks, and presents one request line to a parent processor. Every bank has a view of the registered source levels, a mask word, two write-only ports that set or clear mask bits atomically, and a view of the sources that are both asserted and unmasked. A build has one or two banks, picked by a parameter.

Software reaches the registers through a plain synchronous bus with byte addresses and 32-bit data. Reads return data in the cycle after the request. A source stays pending for as long as its input is high. There is no acknowledge: the handler clears the source at the device, or masks it. The request line is high whenever any pending bit in any bank is set.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every pending word reads zero, and irq_out is low.
- R2: Bank b occupies byte addresses b*0x20 up to b*0x20+0x1F. Inside a bank, word offset 0x00 is the source level view, 0x04 the mask, 0x08 the mask-set port, 0x0C the mask-clear port and 0x10 the pending view.
- R3: A write to offset 0x08 sets every mask bit whose data bit is 1 and leaves every other mask bit unchanged.
- R4: A write to offset 0x0C clears every mask bit whose data bit is 1 and leaves every other mask bit unchanged.
- R5: Source inputs pass through one register. The level view at 0x00 shows the inputs sampled at the previous clock edge.
- R6: Each pending bit equals its registered level AND NOT its mask bit.
- R7: irq_out is the OR of all pending bits of all banks. It follows the registered state in the same cycle, so it rises one clock after an unmasked input rises.
- R8: Writes to offsets 0x00, 0x04 and 0x10 have no effect on any register.
- R9: Reads return zero for unused offsets inside a bank and for bank windows at or above the configured bank count.
- R10: Read data is registered and appears on rd_data one clock after a read request. rd_data is zero in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 32*NUM_BANKS | Level-sensitive sources; bank b uses bits 32b+31:32b |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_out | output | 1 | Combined request to the parent |

## Verification
A corrupted mask bit appears at the ports in two ways. It shows in the next mask read. When the matching source is high, it also changes irq_out and the pending read at once, one clock after the fault. A slip in address decode shows as a write that lands in the wrong bank, or as a read that returns nonzero data from a reserved window. The random phase reads back every bank after each burst of operations, so such a fault shows within a few dozen cycles.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;
   localparam int unsigned SRC_PER_BANK = 32;
   localparam int unsigned BANK_STRIDE  = 32'h20;

   typedef enum logic [2:0] {
      REG_LEVEL  = 3'd0,
      REG_MASK   = 3'd1,
      REG_MSET   = 3'd2,
      REG_MCLR   = 3'd3,
      REG_PEND   = 3'd4,
      REG_NONE   = 3'd7
   } reg_sel_e;

   typedef struct packed {
      logic       hit;
      logic [3:0] bank;
      reg_sel_e   sel;
   } dec_t;
endpackage

// File: rtl/banked_irq_decode.sv
module banked_irq_decode
   import banked_irq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_BANKS = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   localparam int unsigned OFS_W = $clog2(BANK_STRIDE);

   logic [OFS_W-1:0]  ofs;
   logic [ADDR_W-1:0] bank_idx;

   always_comb begin
      ofs      = addr[OFS_W-1:0];
      bank_idx = addr >> OFS_W;
      dec.bank = bank_idx[3:0];
      dec.hit  = (bank_idx < ADDR_W'(NUM_BANKS));
      unique case (ofs)
         5'h00:   dec.sel = REG_LEVEL;
         5'h04:   dec.sel = REG_MASK;
         5'h08:   dec.sel = REG_MSET;
         5'h0C:   dec.sel = REG_MCLR;
         5'h10:   dec.sel = REG_PEND;
         default: dec.sel = REG_NONE;
      endcase
      if (!dec.hit) dec.sel = REG_NONE;
   end
endmodule

// File: rtl/banked_irq_bank.sv
module banked_irq_bank
   import banked_irq_pkg::*;
#(
   parameter int unsigned WIDTH = SRC_PER_BANK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] src,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] pend,
   output logic             any
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
         mask  <= '1;
      end else begin
         level <= src;
         if (set_we)      mask <= mask | wdata;
         else if (clr_we) mask <= mask & ~wdata;
      end
   end

   always_comb begin
      pend = level & ~mask;
      any  = |pend;
   end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
   import banked_irq_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned ADDR_W    = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [SRC_PER_BANK*NUM_BANKS-1:0] src_in,
   input  logic                            bus_wr,
   input  logic                            bus_rd,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic [31:0]                     bus_wdata,
   output logic [31:0]                     rd_data,
   output logic                            irq_out
);
   localparam int unsigned W = SRC_PER_BANK;

   initial begin
      if (NUM_BANKS != 1 && NUM_BANKS != 2)
         $fatal(1, "NUM_BANKS must be 1 or 2");
      if (ADDR_W < $clog2(BANK_STRIDE) + 1)
         $fatal(1, "ADDR_W too narrow for bank windows");
   end

   dec_t dec;

   banked_irq_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) i_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   logic [NUM_BANKS-1:0][W-1:0] lvl, msk, pnd;
   logic [NUM_BANKS-1:0]        any_b;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel_b;
      assign sel_b = bus_wr && (dec.bank == 4'(b));
      banked_irq_bank #(.WIDTH(W)) i_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .src    (src_in[b*W +: W]),
         .set_we (sel_b && dec.sel == REG_MSET),
         .clr_we (sel_b && dec.sel == REG_MCLR),
         .wdata  (bus_wdata),
         .level  (lvl[b]),
         .mask   (msk[b]),
         .pend   (pnd[b]),
         .any    (any_b[b])
      );
   end

   logic [W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (dec.bank == 4'(b)) begin
            case (dec.sel)
               REG_LEVEL: rd_mux = lvl[b];
               REG_MASK:  rd_mux = msk[b];
               REG_PEND:  rd_mux = pnd[b];
               default:   rd_mux = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= '0;
      else if (bus_rd) rd_data <= rd_mux;
      else             rd_data <= '0;
   end

   assign irq_out = |any_b;
endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk
   import banked_irq_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned ADDR_W    = 8
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [SRC_PER_BANK*NUM_BANKS-1:0] src_in,
   input logic                              bus_rd,
   input logic [31:0]                       rd_data,
   input logic                              irq_out,
   input logic [NUM_BANKS-1:0][31:0]        msk,
   input logic [NUM_BANKS-1:0][31:0]        lvl
);
   logic seen;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) seen <= 1'b0; else seen <= 1'b1;

   // R10
   rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen && !$past(bus_rd) |-> rd_data == 32'h0);

   // R5
   level_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> lvl == $past(src_in));

   // R7
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == '0) |-> !irq_out);

   // R1
   all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&msk) |-> !irq_out);
endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .src_in  (src_in),
   .bus_rd  (bus_rd),
   .rd_data (rd_data),
   .irq_out (irq_out),
   .msk     (msk),
   .lvl     (lvl)
);

// File: tb/test_banked_irq_ctrl.sv
module test_banked_irq_ctrl;
   localparam int NB = 2;
   localparam int CLK_PERIOD = 10;

   logic clk = 0, rst_n = 0;
   logic [32*NB-1:0] src_in = '0;
   logic bus_wr = 0, bus_rd = 0;
   logic [7:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rd_data;
   logic irq_out;

   int checks = 0, fails = 0;
   logic [31:0] m_mask [NB];
   logic [31:0] m_lvl  [NB];

   always #(CLK_PERIOD/2) clk = ~clk;

   banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) i_banked_irq_ctrl (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic exp_irq();
      logic r = 0;
      for (int b = 0; b < NB; b++) r |= |(m_lvl[b] & ~m_mask[b]);
      return r;
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
      if (a[4:0] == 5'h08 && a[7:5] < NB) m_mask[a[7:5]] |= d;
      if (a[4:0] == 5'h0C && a[7:5] < NB) m_mask[a[7:5]] &= ~d;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1; bus_addr = a;
      @(negedge clk); bus_rd = 0; d = rd_data;
   endtask

   task automatic set_src(input logic [32*NB-1:0] v);
      @(negedge clk); src_in = v;
      @(negedge clk);
      for (int b = 0; b < NB; b++) m_lvl[b] = v[b*32 +: 32];
   endtask

   task automatic check_bank(int b, string tag);
      logic [31:0] d;
      rd(8'(b*32 + 0), d);    chk({tag," level"}, d, m_lvl[b]);
      rd(8'(b*32 + 4), d);    chk({tag," mask"}, d, m_mask[b]);
      rd(8'(b*32 + 16), d);   chk({tag," pend"}, d, m_lvl[b] & ~m_mask[b]);
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(1234));
      for (int b = 0; b < NB; b++) begin m_mask[b] = '1; m_lvl[b] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 irq", {31'b0, irq_out}, 0);
      rd(8'h04, d); chk("R1 mask0", d, 32'hFFFF_FFFF);
      rd(8'h24, d); chk("R1 mask1", d, 32'hFFFF_FFFF);
      rd(8'h30, d); chk("R1 pend1", d, 0);
      // R10 idle read data
      @(negedge clk); chk("R10 idle", rd_data, 0);
      // R5 one-clock lag
      @(negedge clk); src_in = 64'h0000_0001_8000_0000;
      chk("R7 before edge", {31'b0, irq_out}, 0);
      @(negedge clk);
      m_lvl[0] = 32'h8000_0000; m_lvl[1] = 32'h1;
      rd(8'h00, d); chk("R5 level0", d, 32'h8000_0000);
      rd(8'h20, d); chk("R5 level1", d, 32'h1);
      // R4 clear mask partial
      wr(8'h2C, 32'h0000_0001);
      chk("R7 irq bank1", {31'b0, irq_out}, 1);
      check_bank(1, "R4 R6");
      // R3 set mask re-masks
      wr(8'h28, 32'h0000_0001);
      chk("R3 irq off", {31'b0, irq_out}, 0);
      // R8 writes to read-only offsets ignored
      wr(8'h04, 32'h0); wr(8'h00, 32'h0); wr(8'h10, 32'h0);
      check_bank(0, "R8");
      chk("R8 irq", {31'b0, irq_out}, 0);
      // R2 bank separation
      wr(8'h0C, 32'hFFFF_0000);
      check_bank(0, "R2 b0");
      check_bank(1, "R2 b1");
      chk("R2 irq", {31'b0, irq_out}, 1);
      // R9 unused offsets and banks
      rd(8'h14, d); chk("R9 unused", d, 0);
      rd(8'h08, d); chk("R9 mset read", d, 0);
      rd(8'h44, d); chk("R9 bank2", d, 0);
      wr(8'h4C, 32'hFFFF_FFFF);
      check_bank(0, "R9 b0 untouched");
      // R7 rise timing
      wr(8'h0C, 32'hFFFF_FFFF);
      @(negedge clk); src_in = '0;
      @(negedge clk); m_lvl[0] = 0; m_lvl[1] = 0;
      chk("R7 low", {31'b0, irq_out}, 0);
      src_in[5] = 1;
      #1 chk("R7 comb lag", {31'b0, irq_out}, 0);
      @(negedge clk); m_lvl[0] = 32'h20;
      chk("R7 rise", {31'b0, irq_out}, 1);
      // random phase
      for (int it = 0; it < 300; it++) begin
         int op = $urandom_range(0, 3);
         int b  = $urandom_range(0, NB-1);
         logic [31:0] v = $urandom;
         case (op)
            0: wr(8'(b*32 + 8), v);
            1: wr(8'(b*32 + 12), v);
            2: set_src({$urandom, $urandom});
            default: wr(8'(b*32 + 4*$urandom_range(0,4)), v);
         endcase
         chk("R6 R7 irq", {31'b0, irq_out}, {31'b0, exp_irq()});
         if (it % 20 == 19) begin
            check_bank(0, "R3 R4 R6 rand");
            check_bank(1, "R3 R4 R6 rand");
         end
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule